// File: doc/BRIEF.md
# Masked Counter-Inhibit Alias Register

This block gives supervisor software a filtered view of the machine-level counter-inhibit register. It holds one 32-bit inhibit word, one bit per counter. A request arrives with a CSR address, an operation, write data, the current privilege level, a virtualization flag, a delegation-enable bit and a per-counter enable mask. Bits whose enable-mask bit is set pass straight through to the machine word, for both reads and updates. All other bits read as zero, and writes to them are dropped.

Access is refused in three cases, and a refused access changes nothing. When delegation is switched off, the block reports an illegal-instruction error. When delegation is on and the request comes from a virtualized mode, it reports a virtual-instruction error. When delegation is on and the request comes from non-virtualized user mode, it reports an illegal-instruction error. A full-word machine write port is also provided so the inhibit word can be loaded directly for test.

Top module: `cnt_inhibit_alias`

## Requirements
- R1: Only requests with `csr_addr` equal to 0x120 are decoded (`hit`=1). For any other address, `hit`, `illegal` and `virt_fault` are 0, `rdata` is 0 and the inhibit word is unchanged.
- R2: A granted request returns `rdata` = inhibit word AND `cnt_en` in the same cycle, combinationally.
- R3: Operation encoding: 0 is read, 1 is write, 2 is set, 3 is clear. A granted write, set or clear changes only the bits whose `cnt_en` bit is 1. Write copies `wdata`, set ORs `wdata` in, and clear removes the bits of `wdata`. The new value is visible after the next rising clock edge.
- R4: With `deleg_en`=0, a decoded request raises `illegal`, returns `rdata`=0 and leaves the inhibit word unchanged. This holds for every privilege level and virtualization setting.
- R5: With `deleg_en`=1 and `virt`=1, a decoded request raises `virt_fault` only, returns 0 and leaves the inhibit word unchanged.
- R6: Privilege encoding: 0 is user, 1 is supervisor, 3 is machine. With `deleg_en`=1 and `virt`=0, levels 1 and 3 are granted. Any other level raises `illegal` and leaves the word unchanged.
- R7: When `mwr_en`=1, the full `mwr_data` word is loaded at the next edge. This takes priority over an alias update in the same cycle.
- R8: A synchronous active-high `rst` clears the inhibit word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Request present |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | 32 | Write / set / clear data |
| priv | input | 2 | Privilege level: 0 U, 1 S, 3 M |
| virt | input | 1 | Virtualized mode |
| deleg_en | input | 1 | Counter delegation enable |
| cnt_en | input | 32 | Per-counter delegation mask |
| mwr_en | input | 1 | Machine-side full-word write strobe |
| mwr_data | input | 32 | Machine-side write data |
| hit | output | 1 | Address decodes to the alias |
| rdata | output | 32 | Masked read data |
| illegal | output | 1 | Illegal-instruction error |
| virt_fault | output | 1 | Virtual-instruction error |
| minhibit | output | 32 | Current machine inhibit word |

## Verification
The permission logic is swept across every combination of delegation enable, virtualization, privilege level and operation. This separates the illegal cases from the virtual-fault case and confirms that a refused access leaves the word untouched. Updates are tried with several masks: all ones, all zeros, alternating bits, the low half, every single walking bit, and pseudo-random masks against pseudo-random data. These show whether each bit follows its own mask bit and whether set and clear respect the mask the same way write does. Further requests check that an off-address request is ignored, and that a machine write wins over a same-cycle alias write.

// File: rtl/cia_pkg.sv
package cia_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/cia_access_check.sv
module cia_access_check #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR = 12'h120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              deleg_en,
  output logic              hit,
  output logic              grant,
  output logic              illegal,
  output logic              virt_fault
);
  import cia_pkg::*;

  logic priv_ok;

  always_comb begin
    hit        = valid && (addr == ALIAS_ADDR);
    priv_ok    = (priv == PRIV_S) || (priv == PRIV_M);
    illegal    = 1'b0;
    virt_fault = 1'b0;
    grant      = 1'b0;
    if (hit) begin
      if (!deleg_en)      illegal    = 1'b1;
      else if (virt)      virt_fault = 1'b1;
      else if (!priv_ok)  illegal    = 1'b1;
      else                grant      = 1'b1;
    end
  end

  // R1: no error and no grant without an address hit
  assert_no_err_off_addr_R1: assert property (@(posedge clk) disable iff (rst)
    !hit |-> !(illegal || virt_fault || grant));
  // R4, R5: at most one outcome per decoded request
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({illegal, virt_fault, grant}) <= 1);
  // R5: virtual fault only when delegation is enabled
  assert_vfault_needs_deleg_R5: assert property (@(posedge clk) disable iff (rst)
    virt_fault |-> deleg_en && virt);
endmodule

// File: rtl/cia_merge.sv
module cia_merge #(
  parameter int NCNT = 32
) (
  input  logic [NCNT-1:0] cur,
  input  logic [NCNT-1:0] wdata,
  input  logic [NCNT-1:0] mask,
  input  logic [1:0]      op,
  output logic [NCNT-1:0] nxt,
  output logic            upd
);
  import cia_pkg::*;

  csr_op_e op_e;
  assign op_e = csr_op_e'(op);
  assign upd  = (op_e != OP_READ);

  for (genvar i = 0; i < NCNT; i++) begin : g_bit
    logic nb;
    always_comb begin
      case (op_e)
        OP_WRITE: nb = wdata[i];
        OP_SET:   nb = cur[i] | wdata[i];
        OP_CLEAR: nb = cur[i] & ~wdata[i];
        default:  nb = cur[i];
      endcase
    end
    assign nxt[i] = mask[i] ? nb : cur[i];
  end
endmodule

// File: rtl/cnt_inhibit_alias.sv
module cnt_inhibit_alias #(
  parameter int NCNT = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR = 12'h120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_valid,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        csr_op,
  input  logic [NCNT-1:0]   csr_wdata,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              deleg_en,
  input  logic [NCNT-1:0]   cnt_en,
  input  logic              mwr_en,
  input  logic [NCNT-1:0]   mwr_data,
  output logic              hit,
  output logic [NCNT-1:0]   rdata,
  output logic              illegal,
  output logic              virt_fault,
  output logic [NCNT-1:0]   minhibit
);
  logic            grant;
  logic            upd;
  logic [NCNT-1:0] merged;
  logic [NCNT-1:0] inh_q;

  cia_access_check #(.ADDR_W(ADDR_W), .ALIAS_ADDR(ALIAS_ADDR)) u_chk (
    .clk(clk), .rst(rst), .valid(csr_valid), .addr(csr_addr), .priv(priv),
    .virt(virt), .deleg_en(deleg_en), .hit(hit), .grant(grant),
    .illegal(illegal), .virt_fault(virt_fault)
  );

  cia_merge #(.NCNT(NCNT)) u_merge (
    .cur(inh_q), .wdata(csr_wdata), .mask(cnt_en), .op(csr_op),
    .nxt(merged), .upd(upd)
  );

  always_ff @(posedge clk) begin
    if (rst)                inh_q <= '0;
    else if (mwr_en)        inh_q <= mwr_data;
    else if (grant && upd)  inh_q <= merged;
  end

  assign rdata    = grant ? (inh_q & cnt_en) : '0;
  assign minhibit = inh_q;

  // R2: read data never exposes a non-delegated bit
  assert_rdata_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~cnt_en) == '0);
  // R3: non-delegated bits survive an alias update
  assert_nondeleg_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !mwr_en) |=> ((minhibit & ~$past(cnt_en)) == ($past(minhibit) & ~$past(cnt_en))));
  // R4: refused or missed requests leave the word unchanged
  assert_refused_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!mwr_en && !(hit && !illegal && !virt_fault)) |=> $stable(minhibit));
  // R7: machine write loads the full word
  assert_mwrite_loads_R7: assert property (@(posedge clk) disable iff (rst)
    mwr_en |=> minhibit == $past(mwr_data));
endmodule

// File: tb/tb_cnt_inhibit_alias.sv
module tb_cnt_inhibit_alias;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst;
  logic csr_valid;
  logic [11:0] csr_addr;
  logic [1:0] csr_op;
  logic [N-1:0] csr_wdata;
  logic [1:0] priv;
  logic virt, deleg_en;
  logic [N-1:0] cnt_en;
  logic mwr_en;
  logic [N-1:0] mwr_data;
  logic hit, illegal, virt_fault;
  logic [N-1:0] rdata, minhibit;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  logic [31:0] lfsr = 32'h1357_9bdf;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_inhibit_alias dut (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .priv(priv), .virt(virt),
    .deleg_en(deleg_en), .cnt_en(cnt_en), .mwr_en(mwr_en), .mwr_data(mwr_data),
    .hit(hit), .rdata(rdata), .illegal(illegal), .virt_fault(virt_fault),
    .minhibit(minhibit)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_rand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic access(input logic [11:0] a, input logic [1:0] op, input logic [N-1:0] wd,
                        input logic [1:0] pv, input logic vt, input logic de,
                        input logic [N-1:0] msk, input string req);
    logic on, ok, e_ill, e_vf;
    logic [N-1:0] nb;
    @(negedge clk);
    csr_valid = 1'b1; csr_addr = a; csr_op = op; csr_wdata = wd;
    priv = pv; virt = vt; deleg_en = de; cnt_en = msk;
    #1;
    on    = (a == 12'h120);
    e_ill = on && (!de || (!vt && !(pv == 2'd1 || pv == 2'd3)));
    e_vf  = on && de && vt;
    ok    = on && !e_ill && !e_vf;
    chk({req, " hit"}, {31'd0, hit}, {31'd0, on});
    chk({req, " illegal"}, {31'd0, illegal}, {31'd0, e_ill});
    chk({req, " virt_fault"}, {31'd0, virt_fault}, {31'd0, e_vf});
    chk({req, " rdata"}, rdata, ok ? (model & msk) : '0);
    case (op)
      2'd1: nb = wd;
      2'd2: nb = model | wd;
      2'd3: nb = model & ~wd;
      default: nb = model;
    endcase
    if (ok) model = (model & ~msk) | (nb & msk);
    @(posedge clk); #1;
    csr_valid = 1'b0;
    chk({req, " word"}, minhibit, model);
  endtask

  task automatic mwrite(input logic [N-1:0] d);
    @(negedge clk);
    mwr_en = 1'b1; mwr_data = d;
    @(posedge clk); #1;
    mwr_en = 1'b0;
    model = d;
    chk("R7 machine write", minhibit, model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; csr_valid = 0; csr_addr = 0; csr_op = 0; csr_wdata = 0;
    priv = 0; virt = 0; deleg_en = 0; cnt_en = 0; mwr_en = 0; mwr_data = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset word", minhibit, '0);
    @(negedge clk); rst = 1'b0;

    // R2 / R3: mask patterns, all ops, supervisor granted
    mwrite(32'h5A5A_C3C3);
    for (int op = 0; op < 4; op++) begin
      access(12'h120, 2'(op), 32'hFFFF_0000, 2'd1, 0, 1, 32'hFFFF_FFFF, "R3 full mask");
      access(12'h120, 2'(op), 32'h0F0F_F0F0, 2'd3, 0, 1, 32'hAAAA_AAAA, "R3 alternating mask");
      access(12'h120, 2'(op), 32'hFFFF_FFFF, 2'd1, 0, 1, 32'h0000_0000, "R3 zero mask");
      access(12'h120, 2'(op), 32'h1234_5678, 2'd1, 0, 1, 32'h0000_FFFF, "R3 low half mask");
    end
    access(12'h120, 2'd0, 0, 2'd1, 0, 1, 32'hFFFF_FFFF, "R2 full read");

    // R3 walking single-bit masks
    mwrite('0);
    for (int i = 0; i < N; i++) begin
      access(12'h120, 2'd2, 32'hFFFF_FFFF, 2'd1, 0, 1, 32'd1 << i, "R3 walking set");
      access(12'h120, 2'd0, 0, 2'd1, 0, 1, 32'hFFFF_FFFF, "R2 walking read");
    end
    for (int i = 0; i < N; i += 2)
      access(12'h120, 2'd3, 32'hFFFF_FFFF, 2'd3, 0, 1, 32'd1 << i, "R3 walking clear");

    // permission sweep: R4 R5 R6
    mwrite(32'hDEAD_BEEF);
    for (int de = 0; de < 2; de++)
      for (int vt = 0; vt < 2; vt++)
        for (int pv = 0; pv < 4; pv++)
          for (int op = 0; op < 4; op++)
            access(12'h120, 2'(op), 32'h0123_4567 ^ (32'(op) << 8), 2'(pv), 1'(vt), 1'(de),
                   32'hF0F0_FFFF, de == 0 ? "R4 deleg off" : (vt == 1 ? "R5 virtualized" :
                   ((pv == 1 || pv == 3) ? "R6 granted" : "R6 user level")));

    // R1 off-address requests
    for (int k = 0; k < 8; k++)
      access(12'h120 ^ (12'd1 << k), 2'd1, 32'hFFFF_FFFF, 2'd3, 0, 1, 32'hFFFF_FFFF, "R1 other address");

    // R7 machine write wins over same-cycle alias write
    @(negedge clk);
    csr_valid = 1; csr_addr = 12'h120; csr_op = 2'd1; csr_wdata = 32'hFFFF_FFFF;
    priv = 2'd1; virt = 0; deleg_en = 1; cnt_en = 32'hFFFF_FFFF;
    mwr_en = 1; mwr_data = 32'h0000_00A5;
    @(posedge clk); #1;
    csr_valid = 0; mwr_en = 0; model = 32'h0000_00A5;
    chk("R7 priority over alias write", minhibit, model);

    // pseudo-random masks and data
    for (int t = 0; t < 200; t++) begin
      logic [N-1:0] m, d;
      lfsr = nxt_rand(lfsr); m = lfsr;
      lfsr = nxt_rand(lfsr); d = lfsr;
      access(12'h120, d[1:0], d, 2'd1, 0, 1, m, "R3 random");
    end

    // R8 reset mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); #1; rst = 0; model = '0;
    chk("R8 reset clears", minhibit, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule